// File: doc/BRIEF.md
# Serial Receiver with Sleep and Wake-Up

This block takes an asynchronous serial line and turns each frame into a parallel word in a single holding register. The line is sampled at sixteen times the bit rate, and a sample-enable pulse paces the sampling. Every frame has a low start bit, eight payload bits sent least-significant first, a ninth bit that marks an address, and one stop bit. A completed frame sets a full flag. A one-cycle read strobe from a processor or a DMA engine empties the register. An interrupt request follows the full flag whenever the enable input is high.

The host can put the receiver to sleep. While it sleeps, finished frames are not reported, and the receiver stays asleep until a wake condition occurs. A mode input selects that condition. In address mode, a frame with its ninth bit set wakes the receiver, and that frame is delivered at once. In idle mode, ten bit times of high line with no frame in progress wake the receiver, and it then delivers the next frame. A frame that arrives while the register is still unread raises an overrun flag and leaves the old word in place. A low stop bit raises a framing-error flag, whether the receiver is awake or asleep.

Top module: `uart_wake_rx`

## Requirements
- R1: With `os_tick` high, a frame of a low start bit, payload bits 0..7 (LSB first), an address bit and a stop bit, each lasting 16 ticks, loads the payload into `rx_data`, loads the address bit into `rx_adr`, and sets `rx_full`.
- R2: A low pulse on `rx_in` counts as a start bit only when at least two of the samples taken 7, 8 and 9 ticks after the falling edge are low. A shorter glitch produces no frame.
- R3: If a frame completes while `rx_full` is set and no read strobe arrives in the same cycle, `ovr_flag` is set and `rx_data` and `rx_adr` keep their old values.
- R4: A one-cycle `rd_strobe` clears `rx_full`. `ovr_flag` stays set after the read and clears only on a `flag_clr` pulse.
- R5: `irq` is high exactly when `rx_full` is high and `rie` is high.
- R6: A frame whose stop bit is sampled low sets `ferr_flag`, also while asleep. `flag_clr` clears it.
- R7: While `asleep` is high, a frame that does not meet the wake condition leaves `rx_full` and `rx_data` unchanged.
- R8: With `wake_sel`=1 (address mode), a frame received while asleep whose address bit is 1 clears `asleep` and is delivered as in R1.
- R9: With `wake_sel`=0 (idle mode), 160 ticks (ten bit times) of high line with no frame in progress clear `asleep`. The frame that follows is then delivered. In this mode a frame with its address bit set does not wake the receiver.
- R10: A `sleep_req` pulse sets `asleep` at any time.
- R11: After reset, `rx_full`, `ovr_flag`, `ferr_flag`, `irq` and `asleep` are 0, and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Sample enable at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| wake_sel | input | 1 | Wake mode: 0 idle line, 1 address bit |
| rie | input | 1 | Receive interrupt enable |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| rd_strobe | input | 1 | Pulse that empties the data register |
| flag_clr | input | 1 | Pulse that clears the overrun and framing-error flags |
| rx_data | output | 8 | Received payload |
| rx_adr | output | 1 | Address bit of the received frame |
| rx_full | output | 1 | Data register holds an unread frame |
| ovr_flag | output | 1 | Overrun occurred |
| ferr_flag | output | 1 | Framing error occurred |
| irq | output | 1 | Receive interrupt request |
| asleep | output | 1 | Receiver is in the sleep state |

## Verification
The assertions assume that `rst_n` is held low for at least one clock at start-up, that `rd_strobe`, `flag_clr` and `sleep_req` are single-cycle pulses, and that `wake_sel` changes only while no frame is finishing. The stimulus changes every input on the falling clock edge and keeps `os_tick` high, so one bit lasts exactly 16 clocks. The mode input changes only while the line is idle, and each control pulse lasts exactly one cycle, so those assumptions always hold.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_START = 2'd1,
        FS_DATA  = 2'd2,
        FS_STOP  = 2'd3
    } fstate_e;

    typedef enum logic {
        WAKE_IDLE = 1'b0,
        WAKE_ADDR = 1'b1
    } wake_mode_e;
endpackage

// File: rtl/uwr_frame.sv
module uwr_frame
    import uwr_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int NBITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx,
    output logic             busy,
    output logic             done,
    output logic             stop_ok,
    output logic [NBITS-1:0] bits
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(NBITS);
    localparam int MID = OSR / 2;

    typedef struct packed {
        fstate_e          state;
        logic [CW-1:0]    cnt;
        logic [BW-1:0]    bidx;
        logic [NBITS-1:0] shreg;
        logic [1:0]       vt;
        logic             done;
        logic             stop_ok;
    } frame_st_t;

    frame_st_t st_d, st_q;
    logic      maj;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        maj = (st_q.vt[0] & st_q.vt[1]) | (st_q.vt[0] & rx) | (st_q.vt[1] & rx);
        if (tick) begin
            if (st_q.state == FS_IDLE) begin
                if (!rx) begin
                    st_d.state = FS_START;
                    st_d.cnt   = '0;
                end
            end else begin
                if (st_q.cnt == CW'(MID - 1)) st_d.vt[0] = rx;
                if (st_q.cnt == CW'(MID))     st_d.vt[1] = rx;
                st_d.cnt = (st_q.cnt == CW'(OSR - 1)) ? '0 : st_q.cnt + 1'b1;
                if (st_q.cnt == CW'(MID + 1)) begin
                    case (st_q.state)
                        FS_START: if (maj) st_d.state = FS_IDLE;
                        FS_DATA:  st_d.shreg = {maj, st_q.shreg[NBITS-1:1]};
                        FS_STOP: begin
                            st_d.done    = 1'b1;
                            st_d.stop_ok = maj;
                            st_d.state   = FS_IDLE;
                        end
                        default: ;
                    endcase
                end
                if (st_q.cnt == CW'(OSR - 1)) begin
                    if (st_q.state == FS_START) begin
                        st_d.state = FS_DATA;
                        st_d.bidx  = '0;
                    end else if (st_q.state == FS_DATA) begin
                        if (st_q.bidx == BW'(NBITS - 1)) st_d.state = FS_STOP;
                        else st_d.bidx = st_q.bidx + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: FS_IDLE, cnt: '0, bidx: '0, shreg: '0,
                      vt: 2'b11, done: 1'b0, stop_ok: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.state != FS_IDLE);
    assign done    = st_q.done;
    assign stop_ok = st_q.stop_ok;
    assign bits    = st_q.shreg;

    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);
endmodule

// File: rtl/uwr_idle.sv
module uwr_idle #(
    parameter int OSR       = 16,
    parameter int IDLE_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    input  logic busy,
    output logic idle_pulse
);
    localparam int LIM = OSR * IDLE_BITS;
    localparam int CW  = $clog2(LIM + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fired;
        logic          pulse;
    } idle_st_t;

    idle_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!rx) st_d.fired = 1'b0;
        if (!rx || busy) begin
            st_d.cnt = '0;
        end else if (tick && !st_q.fired) begin
            if (st_q.cnt == CW'(LIM - 1)) begin
                st_d.pulse = 1'b1;
                st_d.fired = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, fired: 1'b1, pulse: 1'b0};
        else        st_q <= st_d;
    end

    assign idle_pulse = st_q.pulse;

    assert_idle_needs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pulse |-> $past(rx) && !$past(busy));
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uwr_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int DATA_W    = 8,
    parameter int IDLE_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic              wake_sel,
    input  logic              rie,
    input  logic              sleep_req,
    input  logic              rd_strobe,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_adr,
    output logic              rx_full,
    output logic              ovr_flag,
    output logic              ferr_flag,
    output logic              irq,
    output logic              asleep
);
    localparam int NBITS = DATA_W + 1;

    typedef struct packed {
        logic [1:0]        sync;
        logic [DATA_W-1:0] data;
        logic              adr;
        logic              full;
        logic              ovr;
        logic              ferr;
        logic              asleep;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             f_busy, f_done, f_stop_ok, idle_pulse;
    logic [NBITS-1:0] f_bits;
    logic             wake_hit;
    wake_mode_e       mode;

    uwr_frame #(.OSR(OSR), .NBITS(NBITS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(st_q.sync[1]),
        .busy(f_busy), .done(f_done), .stop_ok(f_stop_ok), .bits(f_bits)
    );

    uwr_idle #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(st_q.sync[1]),
        .busy(f_busy), .idle_pulse(idle_pulse)
    );

    assign mode = wake_mode_e'(wake_sel);

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], rx_in};
        wake_hit  = st_q.asleep && (mode == WAKE_ADDR) && f_bits[NBITS-1];
        if (rd_strobe) st_d.full = 1'b0;
        if (flag_clr) begin
            st_d.ovr  = 1'b0;
            st_d.ferr = 1'b0;
        end
        if (f_done) begin
            if (!f_stop_ok) st_d.ferr = 1'b1;
            if (!st_q.asleep || wake_hit) begin
                if (wake_hit) st_d.asleep = 1'b0;
                if (st_d.full) begin
                    st_d.ovr = 1'b1;
                end else begin
                    st_d.data = f_bits[DATA_W-1:0];
                    st_d.adr  = f_bits[NBITS-1];
                    st_d.full = 1'b1;
                end
            end
        end
        if (idle_pulse && st_q.asleep && mode == WAKE_IDLE) st_d.asleep = 1'b0;
        if (sleep_req) st_d.asleep = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync: 2'b11, data: '0, adr: 1'b0, full: 1'b0,
                      ovr: 1'b0, ferr: 1'b0, asleep: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_data   = st_q.data;
    assign rx_adr    = st_q.adr;
    assign rx_full   = st_q.full;
    assign ovr_flag  = st_q.ovr;
    assign ferr_flag = st_q.ferr;
    assign asleep    = st_q.asleep;
    assign irq       = st_q.full & rie;

    assert_hold_on_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_strobe) |=> $stable(rx_data) && $stable(rx_adr));
    assert_ovr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && !asleep && rx_full && !rd_strobe) |=> ovr_flag);
    assert_full_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(f_done));
    assert_wake_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> $past(f_done) || $past(idle_pulse));
    assert_asleep_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && asleep && !f_bits[NBITS-1]) |=> $stable(rx_data) && !$rose(rx_full));
    assert_ferr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && !f_stop_ok) |=> ferr_flag);
    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_full |-> !irq);
    assert_sleep_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> asleep);
endmodule

// File: tb/uart_wake_rx_bench.sv
module uart_wake_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 16;
    localparam int NVEC       = 5;
    // {stop, addr, data[7:0]}
    localparam logic [9:0] VEC [NVEC] = '{10'h2A5, 10'h33C, 10'h200, 10'h3FF, 10'h081};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rx_in = 1'b1;
    logic       wake_sel = 1'b0;
    logic       rie = 1'b0;
    logic       sleep_req = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_adr, rx_full, ovr_flag, ferr_flag, irq, asleep;
    int         checks = 0;
    int         errors = 0;
    logic       finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_wake_rx u_uart_wake_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .wake_sel(wake_sel), .rie(rie), .sleep_req(sleep_req),
        .rd_strobe(rd_strobe), .flag_clr(flag_clr), .rx_data(rx_data),
        .rx_adr(rx_adr), .rx_full(rx_full), .ovr_flag(ovr_flag),
        .ferr_flag(ferr_flag), .irq(irq), .asleep(asleep)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] b, input logic stop);
        rx_in = 1'b0;
        idle_clks(BIT_CLKS);
        for (int i = 0; i < 9; i++) begin
            rx_in = b[i];
            idle_clks(BIT_CLKS);
        end
        rx_in = stop;
        idle_clks(BIT_CLKS);
        rx_in = 1'b1;
        idle_clks(4);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    initial begin
        int wd = 0;
        while (!finished && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_clks(3);
        // R11 reset state
        check("R11 full", rx_full, 0);
        check("R11 ovr", ovr_flag, 0);
        check("R11 ferr", ferr_flag, 0);
        check("R11 asleep", asleep, 0);
        check("R11 data", rx_data, 0);
        rst_n = 1'b1;
        idle_clks(2 * BIT_CLKS);

        // R1 / R6 vector table
        for (int v = 0; v < NVEC; v++) begin
            send(VEC[v][8:0], VEC[v][9]);
            check("R1 data", rx_data, VEC[v][7:0]);
            check("R1 adr", rx_adr, VEC[v][8]);
            check("R1 full", rx_full, 1);
            check("R6 ferr", ferr_flag, !VEC[v][9]);
            pulse(rd_strobe);
            pulse(flag_clr);
            idle_clks(BIT_CLKS);
            check("R4 read empties", rx_full, 0);
            check("R6 flag_clr", ferr_flag, 0);
        end

        // R2 glitch rejected
        rx_in = 1'b0;
        idle_clks(5);
        rx_in = 1'b1;
        idle_clks(12 * BIT_CLKS);
        check("R2 glitch no frame", rx_full, 0);
        check("R2 glitch no ferr", ferr_flag, 0);

        // R5 interrupt gating
        send(9'h011, 1'b1);
        check("R5 irq off", irq, 0);
        rie = 1'b1;
        @(negedge clk);
        check("R5 irq on", irq, 1);

        // R3 overrun keeps old data
        send(9'h0C3, 1'b1);
        check("R3 ovr", ovr_flag, 1);
        check("R3 data kept", rx_data, 8'h11);
        pulse(rd_strobe);
        check("R4 full cleared", rx_full, 0);
        check("R5 irq low", irq, 0);
        check("R4 ovr sticky", ovr_flag, 1);
        pulse(flag_clr);
        check("R4 ovr cleared", ovr_flag, 0);
        rie = 1'b0;

        // R10 / R7 / R8 address wake
        wake_sel = 1'b1;
        pulse(sleep_req);
        check("R10 asleep", asleep, 1);
        send(9'h044, 1'b1);
        check("R7 not delivered", rx_full, 0);
        check("R7 data same", rx_data, 8'h11);
        check("R8 still asleep", asleep, 1);
        idle_clks(15 * BIT_CLKS);
        check("R8 idle ignored", asleep, 1);
        send(9'h055, 1'b0);
        check("R6 ferr asleep", ferr_flag, 1);
        check("R7 no full on err", rx_full, 0);
        pulse(flag_clr);
        idle_clks(BIT_CLKS);
        send(9'h15A, 1'b1);
        check("R8 woke", asleep, 0);
        check("R8 delivered", rx_data, 8'h5A);
        check("R8 adr", rx_adr, 1);
        check("R8 full", rx_full, 1);
        pulse(rd_strobe);

        // R9 idle wake
        wake_sel = 1'b0;
        pulse(sleep_req);
        send(9'h177, 1'b1);
        check("R9 addr no wake", asleep, 1);
        check("R9 not delivered", rx_full, 0);
        idle_clks(100);
        check("R9 too early", asleep, 1);
        idle_clks(100);
        check("R9 woke", asleep, 0);
        send(9'h066, 1'b1);
        check("R9 next frame", rx_data, 8'h66);
        check("R9 next full", rx_full, 1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule